// File: doc/BRIEF.md
# AES Key Store Area Manager

This block holds the key material for an AES engine in a small on-chip store of eight 128-bit key areas. A key is written as a stream of 32-bit words. The write command names a target area and a key size code. A 128-bit key fills exactly one area. A 192-bit or 256-bit key fills an aligned pair of areas: (0,1), (2,3), (4,5) or (6,7). Naming either member of a pair, odd ones included, selects that pair.

All valid keys in the store share one size. A write whose size differs from the current size first drops every valid bit in the store. A read command names one area. If that area holds a valid key, the block streams the whole key to the engine, starting at the base area of the key and going up one word at a time. It also reports the key's size code, so the engine never has to supply a length. A one-hot invalidate command deletes a single key.

The control is a three-state machine.
- **IDLE**: accepts one command per cycle. A write start has priority over a read start, and a read start has priority over an invalidate.
- Transitions out of IDLE:
  - *start-load*: IDLE to **LOAD**, taken on a write start.
  - *start-stream*: IDLE to **STREAM**, taken on a read of a valid area.
  - A read of an empty area stays in IDLE and reports a miss.
  - An invalidate stays in IDLE.
- **LOAD**: accepts key words.
  - *load-done*: LOAD to IDLE, taken on the word marked last.
- **STREAM**: presents key words to the engine.
  - *stream-done*: STREAM to IDLE, taken when the final word is accepted.
- Commands that arrive outside IDLE are ignored.

Top module: `aes_keystore_mgr`

## Requirements
- R1: After reset, `area_valid` is 0, `key_size` is 0, and `busy`, `done`, `wr_ready`, `key_valid`, `wr_err` and `rd_err` are all low.
- R2: A successful 128-bit write (size code 0, exactly 4 words) sets only the valid bit of the named area. The other valid bits are unchanged if the size code did not change.
- R3: A successful write with size code 1 (192-bit, exactly 6 words) or size code 2 (256-bit, exactly 8 words) sets the valid bits of both areas of the aligned pair that contains the named area, odd area numbers included.
- R4: A write whose size code differs from `key_size` clears every valid bit. `key_size` then takes the new code, even if the write later fails.
- R5: A read of an area whose valid bit is 0 transfers no word. One cycle later it gives a `done` pulse with `status` = 1 and an `rd_err` pulse.
- R6: A read of a valid area streams the key's words in ascending order, starting at the key's base area. The stream is 4, 6 or 8 words long for size codes 0, 1 and 2. `key_last` marks the final word, and `key_size` gives the stored size code.
- R7: While `key_valid` is high and `key_ready` is low, `key_data` and `key_last` hold their values. When `key_ready` is high, one word is accepted on each clock.
- R8: Invalidating with `inv_mask` = 1 << area clears that area's valid bit. When the store holds two-area keys, it clears both areas of the pair.
- R9: A write whose word count differs from the count for its size code gives a `done` pulse with `status` = 2 and a `wr_err` pulse. The target areas are left invalid. Words beyond the expected count are not stored, so keys in neighbouring areas read back unchanged.
- R10: A successful write or read gives a `done` pulse with `status` = 0 one cycle after its final handshake. A valid bit is set only at that point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_start | input | 1 | Begin a key write (accepted in IDLE) |
| wr_area | input | 3 | Target area of the write |
| wr_size | input | 2 | Key size code: 0 = 128, 1 = 192, 2 = 256 bits |
| wr_valid | input | 1 | A key word is present on `wr_data` |
| wr_data | input | 32 | Key word |
| wr_last | input | 1 | Marks the final word of the write |
| wr_ready | output | 1 | High in LOAD; a word is taken when this and `wr_valid` are both high |
| rd_start | input | 1 | Begin a key read (accepted in IDLE) |
| rd_area | input | 3 | Area named by the read |
| key_valid | output | 1 | A key word is presented to the engine |
| key_data | output | 32 | Key word to the engine |
| key_last | output | 1 | Marks the final word of the key |
| key_ready | input | 1 | Engine accepts the current word |
| key_size | output | 2 | Size code shared by all stored keys |
| inv_valid | input | 1 | Apply an invalidate (accepted in IDLE) |
| inv_mask | input | 8 | One-hot area to invalidate |
| area_valid | output | 8 | One valid bit per area |
| busy | output | 1 | The machine is in LOAD or STREAM |
| done | output | 1 | One-cycle pulse when a command completes |
| status | output | 2 | Result with `done`: 0 = success, 1 = no key in area, 2 = bad word count |
| wr_err | output | 1 | Key-store write-error pulse |
| rd_err | output | 1 | Key-store read-error pulse |

## Verification
The hardest situation to reach is an over-long write aimed at an area that sits next to a live key. Reaching it takes three steps: a key of the same size must already be present, a second write must target the neighbouring area, and that write must run past its expected word count. Only a later read of the neighbour shows whether the extra words were dropped.

The directed sequence builds this case on purpose. It loads area 3, then sends a six-word 128-bit write to area 2, then reads area 3 back. The random phase mixes sizes, word counts that are off by one, odd pair areas, invalidates and consumer stalls. These cases are checked against a word-level model of the store kept in the bench.

// File: rtl/ks_pkg.sv
package ks_pkg;

    typedef enum logic [1:0] {
        KS_SZ128 = 2'd0,
        KS_SZ192 = 2'd1,
        KS_SZ256 = 2'd2,
        KS_SZRSV = 2'd3
    } ks_size_e;

    typedef enum logic [1:0] {
        KS_OK     = 2'd0,
        KS_NOKEY  = 2'd1,
        KS_BADLEN = 2'd2
    } ks_status_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_LOAD,
        S_STREAM
    } ks_state_e;

    // Any code other than 128-bit spans a pair of areas.
    function automatic logic ks_two(input logic [1:0] sz);
        return sz != KS_SZ128;
    endfunction

endpackage

// File: rtl/ks_area_table.sv
// Per-area valid bits and the size code shared by all stored keys.
module ks_area_table #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wipe_all,
    input  logic [N-1:0] clr_mask,
    input  logic [N-1:0] set_mask,
    input  logic         size_load,
    input  logic [1:0]   size_in,
    output logic [N-1:0] valid,
    output logic [1:0]   size
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid <= '0;
            size  <= 2'd0;
        end else begin
            valid <= ((wipe_all ? '0 : valid) & ~clr_mask) | set_mask;
            if (size_load) begin
                size <= size_in;
            end
        end
    end

endmodule

// File: rtl/ks_mask_gen.sv
// Turns an area number or a one-hot invalidate into the set of areas touched.
module ks_mask_gen #(
    parameter int N  = 8,
    parameter int AW = 3
) (
    input  logic [AW-1:0] area,
    input  logic          sel_two,
    input  logic [N-1:0]  inv_bits,
    input  logic          inv_two,
    output logic [N-1:0]  sel_mask,
    output logic [N-1:0]  inv_clear
);

    always_comb begin
        sel_mask       = '0;
        sel_mask[area] = 1'b1;
        if (sel_two) begin
            sel_mask[{area[AW-1:1], 1'b0}] = 1'b1;
            sel_mask[{area[AW-1:1], 1'b1}] = 1'b1;
        end
    end

    always_comb begin
        inv_clear = '0;
        for (int i = 0; i < N; i++) begin
            if (inv_bits[i]) begin
                inv_clear[i] = 1'b1;
                if (inv_two) begin
                    inv_clear[i ^ 1] = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/ks_word_store.sv
// Word-addressed key storage; whole areas are zeroed on command, which also
// leaves the unused tail of a 192-bit pair at zero.
module ks_word_store #(
    parameter int N   = 8,
    parameter int WPA = 4,
    parameter int W   = 32,
    localparam int DEPTH = N * WPA,
    localparam int DW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  clr_areas,
    input  logic          we,
    input  logic [DW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [DW-1:0] raddr,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (clr_areas[i / WPA]) begin
                    mem[i] <= '0;
                end else if (we && (waddr == DW'(i))) begin
                    mem[i] <= wdata;
                end
            end
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/aes_keystore_mgr.sv
module aes_keystore_mgr
    import ks_pkg::*;
#(
    parameter int N   = 8,
    parameter int W   = 32,
    parameter int WPA = 4,
    localparam int AW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_start,
    input  logic [AW-1:0] wr_area,
    input  logic [1:0]    wr_size,
    input  logic          wr_valid,
    input  logic [W-1:0]  wr_data,
    input  logic          wr_last,
    output logic          wr_ready,
    input  logic          rd_start,
    input  logic [AW-1:0] rd_area,
    output logic          key_valid,
    output logic [W-1:0]  key_data,
    output logic          key_last,
    input  logic          key_ready,
    output logic [1:0]    key_size,
    input  logic          inv_valid,
    input  logic [N-1:0]  inv_mask,
    output logic [N-1:0]  area_valid,
    output logic          busy,
    output logic          done,
    output logic [1:0]    status,
    output logic          wr_err,
    output logic          rd_err
);

    localparam int DEPTH = N * WPA;
    localparam int DW    = $clog2(DEPTH);
    localparam int CW    = $clog2(2 * WPA + 1) + 1;

    function automatic logic [CW-1:0] words_of(input logic [1:0] sz);
        unique case (sz)
            KS_SZ128: return CW'(WPA);
            KS_SZ192: return CW'(WPA + WPA / 2);
            default:  return CW'(2 * WPA);
        endcase
    endfunction

    function automatic logic [AW-1:0] base_of(input logic [AW-1:0] a, input logic two);
        return two ? {a[AW-1:1], 1'b0} : a;
    endfunction

    ks_state_e       state_q, state_d;
    logic [AW-1:0]   base_q;
    logic            two_q;
    logic [CW-1:0]   exp_q, cnt_q;

    logic            wipe_all, size_load, we;
    logic [N-1:0]    clr_mask, set_mask, sel_mask, inv_clear;
    logic            fin_ok, fin_bad, miss, rd_ok, start_wr, start_rd;
    logic [DW-1:0]   addr;
    logic [AW-1:0]   mask_area;
    logic            mask_two;

    assign mask_area = (state_q == S_IDLE) ? wr_area : base_q;
    assign mask_two  = (state_q == S_IDLE) ? ks_two(wr_size) : two_q;
    assign addr      = DW'(base_q) * DW'(WPA) + DW'(cnt_q);

    ks_mask_gen #(.N(N), .AW(AW)) u_mask (
        .area      (mask_area),
        .sel_two   (mask_two),
        .inv_bits  (inv_mask),
        .inv_two   (ks_two(key_size)),
        .sel_mask  (sel_mask),
        .inv_clear (inv_clear)
    );

    ks_area_table #(.N(N)) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .wipe_all  (wipe_all),
        .clr_mask  (clr_mask),
        .set_mask  (set_mask),
        .size_load (size_load),
        .size_in   (wr_size),
        .valid     (area_valid),
        .size      (key_size)
    );

    ks_word_store #(.N(N), .WPA(WPA), .W(W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_areas (clr_mask),
        .we        (we),
        .waddr     (addr),
        .wdata     (wr_data),
        .raddr     (addr),
        .rdata     (key_data)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and per-cycle controls
    always_comb begin
        state_d   = state_q;
        wipe_all  = 1'b0;
        size_load = 1'b0;
        clr_mask  = '0;
        set_mask  = '0;
        we        = 1'b0;
        fin_ok    = 1'b0;
        fin_bad   = 1'b0;
        miss      = 1'b0;
        rd_ok     = 1'b0;
        start_wr  = 1'b0;
        start_rd  = 1'b0;
        wr_ready  = 1'b0;
        key_valid = 1'b0;
        key_last  = 1'b0;
        busy      = (state_q != S_IDLE);
        unique case (state_q)
            S_IDLE: begin
                if (wr_start) begin
                    state_d   = S_LOAD;
                    start_wr  = 1'b1;
                    size_load = 1'b1;
                    wipe_all  = (wr_size != key_size);
                    clr_mask  = sel_mask;
                end else if (rd_start) begin
                    if (area_valid[rd_area]) begin
                        state_d  = S_STREAM;
                        start_rd = 1'b1;
                    end else begin
                        miss = 1'b1;
                    end
                end else if (inv_valid) begin
                    clr_mask = inv_clear;
                end
            end
            S_LOAD: begin
                wr_ready = 1'b1;
                if (wr_valid) begin
                    we = (cnt_q < exp_q);
                    if (wr_last) begin
                        state_d = S_IDLE;
                        if ((cnt_q + CW'(1)) == exp_q) begin
                            set_mask = sel_mask;
                            fin_ok   = 1'b1;
                        end else begin
                            fin_bad = 1'b1;
                        end
                    end
                end
            end
            S_STREAM: begin
                key_valid = 1'b1;
                key_last  = (cnt_q == exp_q - CW'(1));
                if (key_ready && key_last) begin
                    state_d = S_IDLE;
                    rd_ok   = 1'b1;
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    // Registered results and transfer bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            two_q  <= 1'b0;
            exp_q  <= '0;
            cnt_q  <= '0;
            done   <= 1'b0;
            status <= KS_OK;
            wr_err <= 1'b0;
            rd_err <= 1'b0;
        end else begin
            done   <= fin_ok | fin_bad | miss | rd_ok;
            status <= fin_bad ? KS_BADLEN : (miss ? KS_NOKEY : KS_OK);
            wr_err <= fin_bad;
            rd_err <= miss;
            if (start_wr) begin
                base_q <= base_of(wr_area, ks_two(wr_size));
                two_q  <= ks_two(wr_size);
                exp_q  <= words_of(wr_size);
                cnt_q  <= '0;
            end else if (start_rd) begin
                base_q <= base_of(rd_area, ks_two(key_size));
                two_q  <= ks_two(key_size);
                exp_q  <= words_of(key_size);
                cnt_q  <= '0;
            end else if (state_q == S_LOAD && wr_valid && cnt_q != {CW{1'b1}}) begin
                cnt_q <= cnt_q + CW'(1);
            end else if (state_q == S_STREAM && key_ready) begin
                cnt_q <= cnt_q + CW'(1);
            end
        end
    end

endmodule

// File: rtl/ks_chk.sv
module ks_chk #(
    parameter int N = 8,
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         wr_ready,
    input logic         key_valid,
    input logic [W-1:0] key_data,
    input logic         key_last,
    input logic         key_ready,
    input logic [1:0]   key_size,
    input logic [N-1:0] area_valid,
    input logic         done,
    input logic [1:0]   status,
    input logic         wr_err,
    input logic         rd_err
);

    function automatic logic [N-1:0] even_bits();
        logic [N-1:0] m;
        m = '0;
        for (int i = 0; i < N; i += 2) m[i] = 1'b1;
        return m;
    endfunction

    localparam logic [N-1:0] EVEN = even_bits();

    // R7
    key_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid && !key_ready |=> key_valid && $stable(key_data) && $stable(key_last));

    // R7
    one_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_ready && key_valid));

    // R5
    miss_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done && status == 2'd1 |-> rd_err && !key_valid);

    // R9
    wr_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |-> done && status == 2'd2);

    // R10
    set_only_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (area_valid & ~$past(area_valid)) != '0 |-> done && status == 2'd0);

    // R6
    stream_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid |-> area_valid != '0);

    // R4
    size_wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        key_size != $past(key_size) |-> area_valid == '0);

    // R3
    pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        key_size != 2'd0 |-> (area_valid & EVEN) == ((area_valid >> 1) & EVEN));

endmodule

bind aes_keystore_mgr ks_chk #(.N(N), .W(W)) u_ks_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_ready   (wr_ready),
    .key_valid  (key_valid),
    .key_data   (key_data),
    .key_last   (key_last),
    .key_ready  (key_ready),
    .key_size   (key_size),
    .area_valid (area_valid),
    .done       (done),
    .status     (status),
    .wr_err     (wr_err),
    .rd_err     (rd_err)
);

// File: tb/test_aes_keystore_mgr.sv
module test_aes_keystore_mgr;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_start = 1'b0, wr_valid = 1'b0, wr_last = 1'b0;
    logic [2:0]  wr_area = '0, rd_area = '0;
    logic [1:0]  wr_size = '0;
    logic [31:0] wr_data = '0;
    logic        wr_ready, rd_start = 1'b0, key_valid, key_last, key_ready = 1'b0;
    logic [31:0] key_data;
    logic [1:0]  key_size, status;
    logic        inv_valid = 1'b0;
    logic [7:0]  inv_mask = '0, area_valid;
    logic        busy, done, wr_err, rd_err;

    int checks = 0;
    int failures = 0;

    logic [31:0] m_mem [32];
    logic [7:0]  m_valid = '0;
    logic [1:0]  m_size = '0;

    always #10 clk = ~clk;

    aes_keystore_mgr i_aes_keystore_mgr (
        .clk(clk), .rst_n(rst_n),
        .wr_start(wr_start), .wr_area(wr_area), .wr_size(wr_size),
        .wr_valid(wr_valid), .wr_data(wr_data), .wr_last(wr_last), .wr_ready(wr_ready),
        .rd_start(rd_start), .rd_area(rd_area),
        .key_valid(key_valid), .key_data(key_data), .key_last(key_last),
        .key_ready(key_ready), .key_size(key_size),
        .inv_valid(inv_valid), .inv_mask(inv_mask),
        .area_valid(area_valid), .busy(busy), .done(done), .status(status),
        .wr_err(wr_err), .rd_err(rd_err)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int words_of(input logic [1:0] sz);
        return (sz == 2'd0) ? 4 : (sz == 2'd1) ? 6 : 8;
    endfunction

    function automatic logic [7:0] sel_of(input int area, input logic [1:0] sz);
        logic [7:0] m;
        m = 8'h01 << area;
        if (sz != 2'd0) m = 8'h03 << (area & 6);
        return m;
    endfunction

    function automatic int base_of(input int area, input logic [1:0] sz);
        return (sz != 2'd0) ? (area & 6) : area;
    endfunction

    task automatic zero_areas(input logic [7:0] m);
        for (int a = 0; a < 8; a++)
            if (m[a]) for (int k = 0; k < 4; k++) m_mem[a*4+k] = '0;
    endtask

    task automatic wr_key(input int area, input logic [1:0] sz, input int n, input bit gaps);
        logic [7:0] m;
        int exp_n, base;
        @(negedge clk);
        wr_start = 1'b1; wr_area = 3'(area); wr_size = sz;
        @(negedge clk);
        wr_start = 1'b0;
        if (sz != m_size) m_valid = '0;
        m_size = sz;
        m = sel_of(area, sz);
        m_valid &= ~m;
        zero_areas(m);
        exp_n = words_of(sz);
        base = base_of(area, sz);
        chk("R4 size code", 64'(key_size), 64'(sz));
        for (int k = 0; k < n; k++) begin
            if (gaps && ($urandom % 3 == 0)) begin
                wr_valid = 1'b0;
                @(negedge clk);
            end
            chk("R7 wr_ready in load", 64'(wr_ready), 64'd1);
            wr_valid = 1'b1; wr_data = $urandom; wr_last = (k == n - 1);
            if (k < exp_n) m_mem[base*4+k] = wr_data;
            @(negedge clk);
        end
        wr_valid = 1'b0; wr_last = 1'b0;
        chk("R10 write done", 64'(done), 64'd1);
        if (n == exp_n) begin
            m_valid |= m;
            chk("R10 write status", 64'(status), 64'd0);
            chk("R9 no wr_err", 64'(wr_err), 64'd0);
        end else begin
            chk("R9 bad count status", 64'(status), 64'd2);
            chk("R9 wr_err", 64'(wr_err), 64'd1);
        end
        chk("R2 R3 R4 R9 valid bits", 64'(area_valid), 64'(m_valid));
    endtask

    task automatic rd_key(input int area, input bit stalls);
        int n, base;
        logic [31:0] held;
        @(negedge clk);
        rd_start = 1'b1; rd_area = 3'(area);
        @(negedge clk);
        rd_start = 1'b0;
        if (!m_valid[area]) begin
            chk("R5 miss done", 64'(done), 64'd1);
            chk("R5 miss status", 64'(status), 64'd1);
            chk("R5 rd_err", 64'(rd_err), 64'd1);
            chk("R5 no transfer", 64'(key_valid), 64'd0);
            return;
        end
        n = words_of(m_size);
        base = base_of(area, m_size);
        chk("R6 key size", 64'(key_size), 64'(m_size));
        for (int k = 0; k < n; k++) begin
            if (stalls && ($urandom % 2 == 0)) begin
                key_ready = 1'b0;
                held = key_data;
                @(negedge clk);
                chk("R7 held word", 64'(key_data), 64'(held));
                chk("R7 still valid", 64'(key_valid), 64'd1);
            end
            key_ready = 1'b1;
            chk("R6 key valid", 64'(key_valid), 64'd1);
            chk("R6 word", 64'(key_data), 64'(m_mem[base*4+k]));
            chk("R6 last flag", 64'(key_last), 64'(k == n - 1));
            @(negedge clk);
        end
        key_ready = 1'b0;
        chk("R10 read done", 64'(done), 64'd1);
        chk("R10 read status", 64'(status), 64'd0);
        chk("R6 stream ended", 64'(key_valid), 64'd0);
    endtask

    task automatic inv_key(input int area);
        @(negedge clk);
        inv_valid = 1'b1; inv_mask = 8'h01 << area;
        @(negedge clk);
        inv_valid = 1'b0;
        if (m_size != 2'd0) begin
            m_valid[area] = 1'b0; m_valid[area ^ 1] = 1'b0;
            zero_areas(8'h03 << (area & 6));
        end else begin
            m_valid[area] = 1'b0;
            zero_areas(8'h01 << area);
        end
        chk("R8 invalidate", 64'(area_valid), 64'(m_valid));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=hung expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 32; i++) m_mem[i] = '0;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk("R1 area_valid", 64'(area_valid), 64'd0);
        chk("R1 key_size", 64'(key_size), 64'd0);
        chk("R1 idle outputs", 64'({busy, done, wr_ready, key_valid, wr_err, rd_err}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: 128-bit keys occupy one area
        wr_key(3, 2'd0, 4, 1'b0);
        wr_key(0, 2'd0, 4, 1'b1);
        rd_key(3, 1'b0);
        rd_key(0, 1'b1);
        rd_key(5, 1'b0);              // R5
        // R3/R4: odd base for a 256-bit key wipes the 128-bit keys
        wr_key(5, 2'd2, 8, 1'b0);
        rd_key(4, 1'b0);
        rd_key(5, 1'b1);
        wr_key(1, 2'd2, 8, 1'b1);
        wr_key(7, 2'd1, 6, 1'b0);     // R4 size change to 192
        rd_key(6, 1'b1);
        rd_key(0, 1'b0);              // R5 wiped area
        // R8: invalidate one member of a pair
        inv_key(7);
        rd_key(6, 1'b0);
        // R9: word count mismatches with a live neighbour
        wr_key(3, 2'd0, 4, 1'b0);
        wr_key(2, 2'd0, 3, 1'b0);
        wr_key(2, 2'd0, 6, 1'b0);
        rd_key(3, 1'b0);
        rd_key(2, 1'b0);
        wr_key(4, 2'd2, 9, 1'b0);

        // random mix
        for (int it = 0; it < 200; it++) begin
            int op;
            op = $urandom % 4;
            if (op == 0) begin
                logic [1:0] sz;
                int n;
                sz = 2'($urandom % 3);
                n = words_of(sz);
                if ($urandom % 5 == 0) n = n + ((($urandom % 2) == 0) ? -1 : 1);
                wr_key($urandom % 8, sz, n, 1'b1);
            end else if (op == 3) begin
                inv_key($urandom % 8);
            end else begin
                rd_key($urandom % 8, 1'b1);
            end
        end

        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule